// File: doc/BRIEF.md
# Indirect Byte-Array Access Port with Auto-Advance

This block lets a narrow host bus reach a 256-entry, byte-wide storage array through a pair of register locations rather than a memory window. The host first writes the target entry number into a pointer location. It then reads or writes a data-port location, and each access there reaches the entry the pointer selects. A third location holds a control register. Its lowest bit turns on burst mode, in which every completed data-port access moves the pointer forward by one. The pointer wraps from the top entry back to entry zero.

The bus uses active-low chip select, output enable and write enable, an 8-bit register offset and separate write and read data buses. All of them are sampled on the block clock. An access lasts from the first cycle in which chip select and one of the two enables are low until the first cycle in which that is no longer true. Register updates take effect at that trailing edge. An input that reports main power gates writes into the array. While it is low, the array keeps its contents, and the pointer and control registers keep working.

Top module: `idxRamPort`

## Requirements
- R1: After reset the pointer reads 00h and the burst-enable bit (bit 0 of offset 14h) reads 0.
- R2: A write to offset 10h loads the pointer. A read of offset 10h returns the current pointer, including increments made by burst mode.
- R3: A write to offset 13h stores the data byte into the entry the pointer selects, and a read of offset 13h returns that entry. Writes take effect at the trailing edge of the strobe.
- R4: With the burst-enable bit at 0, repeated data-port reads and writes keep reaching the same entry, and the pointer keeps its value.
- R5: With the burst-enable bit at 1, the pointer rises by one at the trailing edge of every data-port access, read or write. Read data during the access comes from the entry selected before the increment.
- R6: A burst-mode increment from FFh gives 00h.
- R7: Accesses to any offset other than 13h never change the pointer, in either mode.
- R8: While main power is reported absent (mainPowerOk = 0), data-port writes leave the array unchanged, but burst mode still advances the pointer. Once main power returns, data-port writes store normally.
- R9: Offset 14h holds the control register. Bit 0 is burst enable, and it is loaded from bit 0 of a write. Reads of 14h return that bit in bit 0 and zeros in the other bits.
- R10: rdData is 00h whenever no read is in progress, that is, unless csN = 0, oeN = 0 and weN = 1 all hold. Reads of unused offsets also return 00h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; all bus inputs are sampled on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Active-low chip select |
| oeN | input | 1 | Active-low output enable (read strobe) |
| weN | input | 1 | Active-low write enable (write strobe); takes precedence over oeN |
| offset | input | 8 | Register offset: 10h pointer, 13h data port, 14h control |
| wrData | input | 8 | Write data byte |
| mainPowerOk | input | 1 | High while main power is present; low write-protects the array |
| rdData | output | 8 | Read data, 00h when no read is in progress |

## Verification
The bench goes after the pointer's edges. It checks wrap from FFh to 00h, which a design with a wider or saturating counter would miss by sticking at FFh or walking past the array. It checks that accesses to the pointer, control and unused offsets never advance the pointer in burst mode, which a design that increments on any strobe would fail. It checks that data read during a burst access comes from the entry selected before the increment, which a design that advances at the leading edge would fail by returning the neighbour. Writes made while main power is absent must leave the array untouched but still move the pointer, so a design that drops the increment along with the write would desynchronise every later burst.

// File: rtl/idxRamPkg.sv
package idxRamPkg;

  parameter int ADDR_W = 8;
  parameter int DATA_W = 8;
  localparam int DEPTH = 1 << ADDR_W;

  // Strobes from the bus controller to the datapath, valid for one cycle
  typedef struct packed {
    logic              ptrLoad;
    logic              ptrInc;
    logic              ramWrite;
    logic              ctrlLoad;
    logic [DATA_W-1:0] wrData;
  } idxStrobes_t;

endpackage

// File: rtl/idxRamCtrl.sv
module idxRamCtrl
  import idxRamPkg::*;
#(
  parameter int OFS_W    = 8,
  parameter logic [OFS_W-1:0] PTR_OFS  = 8'h10,
  parameter logic [OFS_W-1:0] DATA_OFS = 8'h13,
  parameter logic [OFS_W-1:0] CTRL_OFS = 8'h14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              oeN,
  input  logic              weN,
  input  logic [OFS_W-1:0]  offset,
  input  logic [DATA_W-1:0] wrData,
  input  logic              mainPowerOk,
  input  logic [ADDR_W-1:0] ptrQ,
  input  logic              burstQ,
  input  logic [DATA_W-1:0] ramRdData,
  output logic [DATA_W-1:0] rdData,
  output idxStrobes_t       strb
);

  logic              accessNow;
  logic              readNow;
  logic              accessQ;
  logic              endPulse;
  logic [OFS_W-1:0]  capOfs;
  logic              capWrite;
  logic [DATA_W-1:0] capData;

  assign accessNow = !csN && (!oeN || !weN);
  assign readNow   = !csN && !oeN && weN;
  assign endPulse  = accessQ && !accessNow;

  // Hold what the access looked like so it can commit when the strobe ends
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accessQ  <= 1'b0;
      capOfs   <= '0;
      capWrite <= 1'b0;
      capData  <= '0;
    end else begin
      accessQ <= accessNow;
      if (accessNow) begin
        capOfs   <= offset;
        capWrite <= !weN;
        capData  <= wrData;
      end
    end
  end

  always_comb begin
    strb.ptrLoad  = endPulse && capWrite && (capOfs == PTR_OFS);
    strb.ctrlLoad = endPulse && capWrite && (capOfs == CTRL_OFS);
    strb.ramWrite = endPulse && capWrite && (capOfs == DATA_OFS) && mainPowerOk;
    strb.ptrInc   = endPulse && (capOfs == DATA_OFS) && burstQ;
    strb.wrData   = capData;
  end

  // Read multiplexer on the live offset
  always_comb begin
    rdData = '0;
    if (readNow) begin
      if (offset == PTR_OFS)       rdData = DATA_W'(ptrQ);
      else if (offset == DATA_OFS) rdData = ramRdData;
      else if (offset == CTRL_OFS) rdData = DATA_W'(burstQ);
    end
  end

endmodule

// File: rtl/idxRamData.sv
module idxRamData
  import idxRamPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  idxStrobes_t       strb,
  output logic [ADDR_W-1:0] ptrQ,
  output logic              burstQ,
  output logic [DATA_W-1:0] ramRdData
);

  logic [DATA_W-1:0] memQ [DEPTH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptrQ   <= '0;
      burstQ <= 1'b0;
    end else begin
      if (strb.ptrLoad)     ptrQ <= strb.wrData[ADDR_W-1:0];
      else if (strb.ptrInc) ptrQ <= ptrQ + 1'b1;
      if (strb.ctrlLoad)    burstQ <= strb.wrData[0];
    end
  end

  // One write-enabled row per entry; contents are not reset
  for (genvar row = 0; row < DEPTH; row++) begin : g_row
    always_ff @(posedge clk) begin
      if (strb.ramWrite && (ptrQ == ADDR_W'(row)))
        memQ[row] <= strb.wrData;
    end
  end

  assign ramRdData = memQ[ptrQ];

endmodule

// File: rtl/idxRamPort.sv
module idxRamPort
  import idxRamPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       oeN,
  input  logic       weN,
  input  logic [7:0] offset,
  input  logic [7:0] wrData,
  input  logic       mainPowerOk,
  output logic [7:0] rdData
);

  idxStrobes_t       strb;
  logic [ADDR_W-1:0] ptrQ;
  logic              burstQ;
  logic [DATA_W-1:0] ramRdData;

  idxRamCtrl #(
    .OFS_W(8), .PTR_OFS(8'h10), .DATA_OFS(8'h13), .CTRL_OFS(8'h14)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .oeN(oeN), .weN(weN),
    .offset(offset), .wrData(wrData), .mainPowerOk(mainPowerOk),
    .ptrQ(ptrQ), .burstQ(burstQ), .ramRdData(ramRdData),
    .rdData(rdData), .strb(strb)
  );

  idxRamData u_data (
    .clk(clk), .rstN(rstN), .strb(strb),
    .ptrQ(ptrQ), .burstQ(burstQ), .ramRdData(ramRdData)
  );

endmodule

// File: rtl/idxRamPortChk.sv
module idxRamPortChk
  import idxRamPkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              csN,
  input logic              oeN,
  input logic              weN,
  input logic [DATA_W-1:0] rdData,
  input logic [ADDR_W-1:0] ptrQ,
  input logic              burstQ,
  input idxStrobes_t       strb
);

  p_reset_state_r1: assert property (@(posedge clk)
    !rstN |=> (ptrQ == '0 && !burstQ));

  p_ptr_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.ptrLoad |=> ptrQ == $past(strb.wrData[ADDR_W-1:0]));

  // R5 and R6: one step forward, modulo the array size
  p_burst_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.ptrInc && !strb.ptrLoad) |=> ptrQ == ADDR_W'($past(ptrQ) + 1'b1));

  p_ptr_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.ptrInc && !strb.ptrLoad) |=> $stable(ptrQ));

  p_ctrl_load_r9: assert property (@(posedge clk) disable iff (!rstN)
    strb.ctrlLoad |=> burstQ == $past(strb.wrData[0]));

  p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    (csN || oeN || !weN) |-> rdData == '0);

endmodule

bind idxRamPort idxRamPortChk u_chk (
  .clk(clk), .rstN(rstN), .csN(csN), .oeN(oeN), .weN(weN),
  .rdData(rdData), .ptrQ(ptrQ), .burstQ(burstQ), .strb(strb)
);

// File: tb/tb_idxRamPort.sv
`timescale 1ns/1ps
module tb_idxRamPort;

  localparam logic [7:0] PTR  = 8'h10;
  localparam logic [7:0] DATA = 8'h13;
  localparam logic [7:0] CTRL = 8'h14;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1, oeN = 1'b1, weN = 1'b1;
  logic [7:0] offset = '0, wrData = '0;
  logic mainPowerOk = 1'b1;
  logic [7:0] rdData;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  logic [7:0] model [256];
  logic [7:0] mPtr = '0;
  logic       mBurst = 1'b0;
  logic       mPower = 1'b1;

  always #4 clk = ~clk;

  idxRamPort dut (
    .clk(clk), .rstN(rstN), .csN(csN), .oeN(oeN), .weN(weN),
    .offset(offset), .wrData(wrData), .mainPowerOk(mainPowerOk), .rdData(rdData)
  );

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      finishRun();
    end
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  // Model of a completed access (expected values from the requirements)
  function automatic logic [7:0] expRead(input logic [7:0] ofs);
    if (ofs == PTR)  return mPtr;
    if (ofs == DATA) return model[mPtr];
    if (ofs == CTRL) return {7'b0, mBurst};
    return 8'h00;
  endfunction

  function automatic void modelWrite(input logic [7:0] ofs, input logic [7:0] d);
    if (ofs == PTR) mPtr = d;
    else if (ofs == CTRL) mBurst = d[0];
    else if (ofs == DATA) begin
      if (mPower) model[mPtr] = d;
      if (mBurst) mPtr = mPtr + 8'd1;
    end
  endfunction

  function automatic void modelRead(input logic [7:0] ofs);
    if (ofs == DATA && mBurst) mPtr = mPtr + 8'd1;
  endfunction

  task automatic busWrite(input logic [7:0] ofs, input logic [7:0] d);
    @(negedge clk);
    csN = 1'b0; weN = 1'b0; offset = ofs; wrData = d;
    @(negedge clk);
    check("R10 write strobe", rdData, 8'h00);
    @(negedge clk);
    csN = 1'b1; weN = 1'b1;
    @(negedge clk);
    modelWrite(ofs, d);
  endtask

  task automatic busRead(input logic [7:0] ofs, input string req);
    @(negedge clk);
    check("R10 idle", rdData, 8'h00);
    csN = 1'b0; oeN = 1'b0; offset = ofs;
    @(negedge clk);
    check(req, rdData, expRead(ofs));
    csN = 1'b1; oeN = 1'b1;
    @(negedge clk);
    modelRead(ofs);
  endtask

  task automatic setPower(input logic p);
    @(negedge clk);
    mainPowerOk = p; mPower = p;
  endtask

  initial begin
    int seed;
    seed = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    busRead(PTR, "R1 pointer after reset");
    busRead(CTRL, "R1 burst bit after reset");

    // Fill the array with burst writes; covers R5 and the R6 wrap
    busWrite(CTRL, 8'h01);
    busRead(CTRL, "R9 control readback");
    busWrite(PTR, 8'h00);
    for (int i = 0; i < 256; i++) busWrite(DATA, 8'(i * 7 + 3));
    busRead(PTR, "R6 pointer wrapped to 00");

    // R2 and R3 with burst off
    busWrite(CTRL, 8'hFE);
    busRead(CTRL, "R9 only bit0 kept");
    busWrite(PTR, 8'h5A);
    busRead(PTR, "R2 pointer readback");
    busWrite(DATA, 8'hC3);
    busRead(DATA, "R3 data readback");
    // R4 repeated access same entry
    busRead(DATA, "R4 repeat read");
    busWrite(DATA, 8'h3C);
    busRead(DATA, "R4 same entry rewritten");
    busRead(PTR, "R4 pointer unchanged");

    // R5 burst reads return pre-increment entry
    busWrite(CTRL, 8'h01);
    busWrite(PTR, 8'h20);
    busRead(DATA, "R5 burst read 20");
    busRead(DATA, "R5 burst read 21");
    busRead(PTR, "R5 pointer advanced");

    // R6 wrap from FF
    busWrite(PTR, 8'hFF);
    busRead(DATA, "R6 read at FF");
    busRead(PTR, "R6 FF wraps to 00");

    // R7 other offsets leave pointer alone in burst mode
    busWrite(PTR, 8'h40);
    busWrite(8'h11, 8'h99);
    busRead(8'h12, "R10 unused offset reads zero");
    busRead(CTRL, "R7 control read");
    busRead(PTR, "R7 pointer unchanged");

    // R8 write protect while power absent, pointer still moves
    setPower(1'b0);
    busWrite(DATA, 8'hEE);
    busRead(PTR, "R8 pointer advanced under protection");
    busWrite(PTR, 8'h40);
    busRead(DATA, "R8 entry kept under protection");
    setPower(1'b1);
    busWrite(PTR, 8'h40);
    busWrite(DATA, 8'h77);
    busWrite(PTR, 8'h40);
    busRead(DATA, "R8 writable after power return");

    // Constrained random mix
    for (int n = 0; n < 400; n++) begin
      int sel;
      logic [7:0] d;
      sel = int'($urandom_range(0, 9));
      d = 8'($urandom);
      case (sel)
        0:       busWrite(PTR, d);
        1, 2:    busWrite(DATA, d);
        3, 4:    busRead(DATA, "R3 random data read");
        5:       busRead(PTR, "R2 random pointer read");
        6:       busWrite(CTRL, d);
        7:       busWrite(8'h11 + 8'(d[1:0]) * 8'h04, d);
        8:       busRead(CTRL, "R9 random control read");
        default: setPower(d[0] | d[1]);
      endcase
    end
    busRead(PTR, "R7 final pointer");
    finishRun();
  end

endmodule